// File: doc/BRIEF.md
# Line-Packet Admission FIFO for Blanking-Interval Data

This block holds bytes captured from vertical-blanking-interval lines until a host reads them out one byte at a time. Each captured line arrives as a packet. The packet is announced by a start pulse that carries its total length, header included. Its bytes then follow on a byte-wide input strobe, starting in the cycle after the start pulse. The admission decision is made once, in the start cycle, against the current free space. A packet that fits is accepted whole. A packet that does not fit is dropped whole.

When a packet is admitted, its full length is reserved at once, so the reported free space already excludes the bytes still to arrive. When a packet is dropped, a sticky overflow flag is raised, and every byte of that packet is discarded as it arrives. A later, shorter packet, such as a two-byte caption payload behind a two-byte header, can still be accepted while a long text packet was turned away and the flag remains set. A threshold comparator tells the host when the fill level rises above a programmable value.

Top module: `vbi_pkt_fifo`

## Requirements
- R1: After reset, `empty` is 1, `fill_level` is 0, `free_space` equals DEPTH, `ovf_err` and `thr_passed` are 0, and `rd_data` is 0.
- R2: A packet whose `pkt_len` is less than or equal to `free_space` in its start cycle (block idle) is admitted. All its bytes are stored, and they are read out in arrival order.
- R3: A packet whose `pkt_len` exceeds `free_space` in its start cycle is dropped. None of its bytes changes `fill_level`, and `ovf_err` is 1 from the following cycle.
- R4: A later packet that fits is admitted even while `ovf_err` is still set from an earlier drop.
- R5: `ovf_err` stays set until a cycle with `err_clear` high, and reads do not clear it. If a drop and `err_clear` fall in the same cycle, the flag ends up set.
- R6: From the cycle after an admitted start, `free_space` equals DEPTH minus `fill_level` minus the bytes of that packet still to arrive.
- R7: `thr_passed` is 1 exactly when `fill_level` is strictly greater than `thresh`.
- R8: A read while `empty` is 1 leaves `rd_data` and `fill_level` unchanged.
- R9: A read and a write in the same cycle leave `fill_level` unchanged and keep the byte order.
- R10: A `pkt_start` while a packet is still in progress is ignored. An `in_valid` byte outside any packet is ignored.
- R11: A read issued with `rd_en` in one cycle presents the oldest byte on `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Announces a new line packet |
| pkt_len | input | LEN_W | Total packet length in bytes, header included, valid with `pkt_start` |
| in_valid | input | 1 | A packet byte is present on `in_data` |
| in_data | input | 8 | Packet byte |
| rd_en | input | 1 | Pop one byte |
| err_clear | input | 1 | Clears the overflow flag |
| thresh | input | CNT_W | Fill-level threshold |
| rd_data | output | 8 | Last byte popped |
| empty | output | 1 | No bytes stored |
| fill_level | output | CNT_W | Bytes stored |
| free_space | output | CNT_W | Bytes neither stored nor reserved |
| ovf_err | output | 1 | Sticky packet-drop flag |
| thr_passed | output | 1 | Fill level above `thresh` |

## Verification
The bench builds the block with DEPTH set to 64 and LEN_W set to 8. With that depth, one 45-byte text packet plus a couple of 4-byte caption packets leave too little room for a second text packet. This brings the reject-long-but-accept-short situation within reach in a few hundred cycles. The same depth lets the bench drain the whole store and then probe the empty-read case. It also lets the bench exercise a drop and a clear that fall in the same cycle, and test the threshold at exactly the fill level and one below it.

// File: rtl/vbi_fifo_pkg.sv
// Shared types for the line-packet admission FIFO.
// Assumes nothing beyond a 1800-2017 compiler.
package vbi_fifo_pkg;

    // Packet intake state: idle, taking an admitted packet, skipping a dropped one.
    typedef enum logic [1:0] {
        ADM_IDLE = 2'd0,
        ADM_TAKE = 2'd1,
        ADM_SKIP = 2'd2
    } adm_state_e;

endpackage

// File: rtl/vbi_admit.sv
// Packet admission control.
// Decides in the start cycle whether a whole packet fits, reserves its
// length when it does, and then gates the following bytes into the store
// or discards them. Assumes bytes arrive only after the start cycle, and
// assumes fill plus the reservation never exceeds DEPTH (this module
// enforces that).
module vbi_admit
    import vbi_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LEN_W = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] fill,
    output logic             wr_en,
    output logic             drop_evt,
    output logic             busy,
    output logic [CNT_W-1:0] reserve,
    output logic [CNT_W-1:0] free_space
);

    localparam int CMP_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;

    adm_state_e       state_q;
    logic [CMP_W-1:0] remain_q;
    logic [CMP_W-1:0] len_ext;
    logic [CMP_W-1:0] free_ext;
    logic             fits;
    logic             start_ok;

    // Free space excludes the outstanding reservation of an admitted packet.
    always_comb begin
        reserve    = (state_q == ADM_TAKE) ? remain_q[CNT_W-1:0] : '0;
        free_space = CNT_W'(DEPTH) - fill - reserve;
    end

    // Whole-packet fit test, evaluated only in the start cycle.
    always_comb begin
        len_ext  = CMP_W'(pkt_len);
        free_ext = CMP_W'(free_space);
        fits     = (len_ext <= free_ext);
        start_ok = (state_q == ADM_IDLE) && pkt_start && (pkt_len != '0);
        drop_evt = start_ok && !fits;
        wr_en    = (state_q == ADM_TAKE) && in_valid;
        busy     = (state_q != ADM_IDLE);
    end

    // Intake state and byte countdown for the packet in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ADM_IDLE;
            remain_q <= '0;
        end else begin
            case (state_q)
                ADM_IDLE: begin
                    if (start_ok) begin
                        remain_q <= len_ext;
                        state_q  <= fits ? ADM_TAKE : ADM_SKIP;
                    end
                end
                ADM_TAKE, ADM_SKIP: begin
                    if (in_valid) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == CMP_W'(1)) begin
                            state_q <= ADM_IDLE;
                        end
                    end
                end
                default: begin
                    state_q  <= ADM_IDLE;
                    remain_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vbi_store.sv
// Byte storage ring with fill counter and registered read port.
// A read while empty is ignored and keeps the previous output byte.
// Assumes the caller never writes when the ring is full.
module vbi_store #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] fill,
    output logic             empty
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic             rd_fire;

    // A pop only happens when something is stored.
    always_comb begin
        rd_fire = rd_en && (fill != '0);
        empty   = (fill == '0);
    end

    // Storage array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr_q] <= wr_data;
        end
    end

    // Pointers, fill count and the registered output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            fill    <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (rd_fire) begin
                rd_data <= mem[rptr_q];
                rptr_q  <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
            case ({wr_en, rd_fire})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/vbi_flags.sv
// Status flags: sticky overflow on packet drop, plus the threshold compare.
// A drop in the same cycle as a clear leaves the flag set.
module vbi_flags #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_evt,
    input  logic             err_clear,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] thresh,
    output logic             ovf_err,
    output logic             thr_passed
);

    // Sticky overflow: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err <= 1'b0;
        end else if (drop_evt) begin
            ovf_err <= 1'b1;
        end else if (err_clear) begin
            ovf_err <= 1'b0;
        end
    end

    // Level above threshold, evaluated on the current fill.
    always_comb begin
        thr_passed = (fill > thresh);
    end

endmodule

// File: rtl/vbi_pkt_fifo.sv
// Top of the line-packet admission FIFO.
// Ties the admission control, the byte store and the status flags together.
// Assumes packet bytes start in the cycle after pkt_start, one per in_valid.
module vbi_pkt_fifo #(
    parameter int DEPTH = 128,
    parameter int LEN_W = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             rd_en,
    input  logic             err_clear,
    input  logic [CNT_W-1:0] thresh,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] fill_level,
    output logic [CNT_W-1:0] free_space,
    output logic             ovf_err,
    output logic             thr_passed
);

    logic             wr_en;
    logic             drop_evt;
    logic             busy;
    logic [CNT_W-1:0] reserve;

    vbi_admit #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_admit (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_len    (pkt_len),
        .in_valid   (in_valid),
        .fill       (fill_level),
        .wr_en      (wr_en),
        .drop_evt   (drop_evt),
        .busy       (busy),
        .reserve    (reserve),
        .free_space (free_space)
    );

    vbi_store #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .fill    (fill_level),
        .empty   (empty)
    );

    vbi_flags #(
        .CNT_W (CNT_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop_evt   (drop_evt),
        .err_clear  (err_clear),
        .fill       (fill_level),
        .thresh     (thresh),
        .ovf_err    (ovf_err),
        .thr_passed (thr_passed)
    );

endmodule

// File: rtl/vbi_pkt_fifo_chk.sv
// Property checker for the line-packet admission FIFO, bound to the top.
module vbi_pkt_fifo_chk #(
    parameter int DEPTH = 128,
    parameter int LEN_W = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_start,
    input logic [LEN_W-1:0] pkt_len,
    input logic             rd_en,
    input logic             err_clear,
    input logic [7:0]       rd_data,
    input logic             empty,
    input logic [CNT_W-1:0] fill_level,
    input logic [CNT_W-1:0] free_space,
    input logic             ovf_err,
    input logic             busy,
    input logic             drop_evt
);

    localparam int CMP_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;

    logic too_long;
    assign too_long = CMP_W'(pkt_len) > CMP_W'(free_space);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (CMP_W'(fill_level) <= CMP_W'(DEPTH)));

    assert_drop_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pkt_start && too_long && !rd_en) |=> (fill_level == $past(fill_level)));

    assert_drop_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> ovf_err);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !err_clear) |=> ovf_err);

    assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !(!busy && pkt_start && too_long && pkt_len != '0)) |=> !ovf_err);

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rd_data));

endmodule

bind vbi_pkt_fifo vbi_pkt_fifo_chk #(
    .DEPTH (DEPTH),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (pkt_start),
    .pkt_len    (pkt_len),
    .rd_en      (rd_en),
    .err_clear  (err_clear),
    .rd_data    (rd_data),
    .empty      (empty),
    .fill_level (fill_level),
    .free_space (free_space),
    .ovf_err    (ovf_err),
    .busy       (busy),
    .drop_evt   (drop_evt)
);

// File: tb/vbi_pkt_fifo_test.sv
// Scoreboard bench: the packet driver queues the bytes it expects to be
// admitted, and the read monitor pops and compares them.
module vbi_pkt_fifo_test;

    localparam int CLK_NS = 10;
    localparam int DEPTH  = 64;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_start = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             rd_en = 1'b0;
    logic             err_clear = 1'b0;
    logic [CNT_W-1:0] thresh = CNT_W'(8);
    logic [7:0]       rd_data;
    logic             empty;
    logic [CNT_W-1:0] fill_level;
    logic [CNT_W-1:0] free_space;
    logic             ovf_err;
    logic             thr_passed;

    int         n_run = 0;
    int         n_fail = 0;
    int         mdl_level = 0;
    logic [7:0] exp_q [$];
    logic [7:0] last_rd = 8'h00;

    vbi_pkt_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_len(pkt_len),
        .in_valid(in_valid), .in_data(in_data), .rd_en(rd_en),
        .err_clear(err_clear), .thresh(thresh), .rd_data(rd_data),
        .empty(empty), .fill_level(fill_level), .free_space(free_space),
        .ovf_err(ovf_err), .thr_passed(thr_passed)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pkt_byte(input logic [7:0] svc, input int len, input int i);
        if (i == 0) return svc;
        if (i == 1) return 8'(len);
        return 8'(svc ^ (i * 7));
    endfunction

    // Driver: announce a packet, predict admission, queue the expected bytes.
    task automatic send_pkt(input logic [7:0] svc, input int len, input bit rd_also,
                            input bit poke_start, input bit clr_at_start);
        bit fits;
        int old_level;
        @(negedge clk);
        old_level = mdl_level;
        fits      = (len <= DEPTH - mdl_level);
        pkt_start = 1'b1;
        pkt_len   = LEN_W'(len);
        err_clear = clr_at_start;
        if (fits) begin
            for (int i = 0; i < len; i++) exp_q.push_back(pkt_byte(svc, len, i));
            mdl_level += len;
        end
        @(negedge clk);
        pkt_start = 1'b0;
        err_clear = 1'b0;
        // R6: the whole length is reserved as soon as the packet is admitted
        check("R6 free after start", int'(free_space),
              fits ? DEPTH - old_level - len : DEPTH - old_level);
        for (int i = 0; i < len; i++) begin
            in_valid  = 1'b1;
            in_data   = pkt_byte(svc, len, i);
            rd_en     = rd_also;
            pkt_start = poke_start && (i == 1);
            pkt_len   = LEN_W'(1);
            @(negedge clk);
            if (rd_also) begin
                last_rd = exp_q.pop_front();
                check("R9 rd during write", int'(rd_data), int'(last_rd));
            end
        end
        if (rd_also) mdl_level -= len;
        in_valid  = 1'b0;
        rd_en     = 1'b0;
        pkt_start = 1'b0;
    endtask

    // Monitor: pop n bytes back to back and compare with the scoreboard.
    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en   = 1'b0;
            last_rd = exp_q.pop_front();
            check("R2/R11 read order", int'(rd_data), int'(last_rd));
        end
        mdl_level -= n;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1 empty", int'(empty), 1);
        check("R1 fill", int'(fill_level), 0);
        check("R1 free", int'(free_space), DEPTH);
        check("R1 ovf", int'(ovf_err), 0);
        check("R1 thr", int'(thr_passed), 0);
        check("R1 rd_data", int'(rd_data), 0);

        send_pkt(8'h11, 4, 0, 0, 0);                 // caption-sized
        check("R2 fill after caption", int'(fill_level), 4);
        check("R7 below thresh", int'(thr_passed), 0);
        send_pkt(8'h22, 45, 0, 0, 0);                // text-sized
        check("R2 fill after text", int'(fill_level), 49);
        check("R7 above thresh", int'(thr_passed), 1);

        send_pkt(8'h33, 45, 0, 0, 0);                // cannot fit: 15 free
        check("R3 fill unchanged on drop", int'(fill_level), 49);
        check("R3 ovf set", int'(ovf_err), 1);

        send_pkt(8'h44, 4, 0, 0, 0);
        check("R4 short admitted", int'(fill_level), 53);
        check("R4 ovf still set", int'(ovf_err), 1);

        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hEE;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 stray byte ignored", int'(fill_level), 53);

        send_pkt(8'h55, 4, 0, 1, 0);                 // start poked mid-packet
        check("R10 mid-packet start ignored", int'(fill_level), 57);
        check("R10 free after", int'(free_space), 7);

        thresh = CNT_W'(57);
        #1 check("R7 equal to thresh", int'(thr_passed), 0);
        thresh = CNT_W'(56);
        #1 check("R7 one above thresh", int'(thr_passed), 1);
        thresh = CNT_W'(8);

        read_n(57);
        check("R2 drained", int'(empty), 1);
        check("R5 read keeps ovf", int'(ovf_err), 1);

        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 empty read data", int'(rd_data), int'(last_rd));
        check("R8 empty read fill", int'(fill_level), 0);

        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check("R5 clear", int'(ovf_err), 0);

        send_pkt(8'h66, 45, 0, 0, 0);
        send_pkt(8'h77, 4, 1, 0, 0);                 // read alongside write
        check("R9 fill unchanged", int'(fill_level), 45);

        send_pkt(8'h88, 45, 0, 0, 1);                // drop with clear same cycle
        check("R5 set wins over clear", int'(ovf_err), 1);
        check("R3 fill after second drop", int'(fill_level), 45);

        read_n(45);
        check("R2 final empty", int'(empty), 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule